// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block drives a word-addressed RAM through a plain one-request-per-cycle port and runs one of four built-in test algorithms on it. Each algorithm is a short list of phases. A phase writes, reads, reads then writes, or read-modify-writes every word of a span, or it holds the port idle for a fixed pause. The data is always a parameter background word or its bitwise complement. Every run opens with eight dummy cycles, and only then is the first write issued.

Each returned read word is checked against the value the current phase expects. The first mismatch freezes its address together with the expected and the observed word. The run still goes to the end of its phase list. When the run ends, the fail flag and the captured fields hold until the next accepted start.

Top module: `membist_seq`

## Requirements
- R1: A one-cycle `start` in idle with `alg_sel` in 0..3 makes `busy` high on the next cycle and clears `done` and `fail`. A `start` with `alg_sel` in 4..7 is ignored, and so is any `start` while `busy` is high.
- R2: The first 8 request cycles of every run carry command 0 (dummy). The first real request follows in the next cycle.
- R3: Algorithm 0 (march) runs these phases in order: write background ascending; ascending read background then write complement; descending read complement then write background; descending read background then write complement; ascending read of the complement. In each read-then-write step the read cycle comes first and the write cycle is next.
- R4: Algorithm 1 (read-modify-write) runs these phases in order: write background; one read-modify-write per word from background to complement; write complement; read-modify-write from complement to background; read background. All phases ascend.
- R5: Algorithm 2 (page) covers one page of 2^PAGE_AW words at a time, from page 0 upward. Within a page it runs, ascending: write background; read background then write complement; read complement then write background. Only then does it move to the next page.
- R6: Algorithm 3 (retention) writes the background, leaves the port idle for exactly PAUSE_CYC cycles, and reads the background back. It then does the same again with the complement.
- R7: A read (command 1 or 3) returns its data on `mem_rdata` in the cycle after the request, and that data is compared with the expected word. The first mismatch of a run latches its address, expected word and actual word. `fail` stays set until the next accepted start, and later mismatches do not change the captured fields.
- R8: Requests are back to back with no idle cycle, except during a retention pause. `done` goes high two cycles after the last request, in the same cycle that `busy` drops, and stays high until the next accepted start.
- R9: Port encoding: `mem_cmd` is 0 dummy, 1 read, 2 write, 3 read-modify-write. A read-modify-write returns the old word and stores `mem_wdata`. `mem_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request pulse |
| alg_sel | input | 3 | Algorithm number |
| mem_req | output | 1 | Request valid this cycle |
| mem_cmd | output | 2 | Request command |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | A mismatch was seen |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word of the first mismatch |
| fail_act | output | DW | Returned word of the first mismatch |

## Verification
The request stream is fully determined, so a wrong phase index, a wrong direction bit, a missed sub-step or a miscounted pause appears on `mem_cmd` or `mem_addr` in the very cycle it goes wrong. The scoreboard compares every request against its expected cycle number. A fault in the compare pipeline shows up only at the end of a run, through `fail` and the captured fields. For that reason the bench injects a stuck bit and an address alias, and each of these faults has exactly one predictable first failing word.

// File: rtl/membist_pkg.sv
// Package: shared types for the memory self-test sequencer.
// Assumes: commands fit in 2 bits; no algorithm has more than 8 phases.
package membist_pkg;

    typedef enum logic [1:0] {
        CMD_DUMMY = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RMW   = 2'd3
    } mem_cmd_e;

    typedef enum logic [2:0] {
        PK_WRITE,
        PK_READ,
        PK_RDWR,
        PK_RMW,
        PK_PAUSE
    } phase_kind_e;

    typedef struct packed {
        phase_kind_e kind;
        logic        down;  // walk from the top address downward
        logic        rinv;  // expected read data is the complement
        logic        winv;  // write data is the complement
        logic        last;  // final phase of the list
    } phase_t;

    localparam logic [2:0] ALG_MARCH  = 3'd0;
    localparam logic [2:0] ALG_RMW    = 3'd1;
    localparam logic [2:0] ALG_PAGE   = 3'd2;
    localparam logic [2:0] ALG_RETAIN = 3'd3;

    localparam int WARM_OPS = 8;

    function automatic phase_t mk_phase(phase_kind_e k, logic dn, logic ri, logic wi, logic ls);
        phase_t p;
        p.kind = k;
        p.down = dn;
        p.rinv = ri;
        p.winv = wi;
        p.last = ls;
        return p;
    endfunction

endpackage

// File: rtl/membist_phase_rom.sv
// Module: phase table, one entry per (algorithm, phase index).
// Assumes: the index never goes past the entry that is flagged last.
module membist_phase_rom
    import membist_pkg::*;
(
    input  logic [2:0] alg,
    input  logic [2:0] idx,
    output phase_t     ph
);
    // Purpose: combinational lookup of the current phase descriptor.
    always_comb begin
        ph = mk_phase(PK_PAUSE, 1'b0, 1'b0, 1'b0, 1'b1);
        unique case (alg)
            ALG_MARCH: case (idx)
                3'd0:    ph = mk_phase(PK_WRITE, 1'b0, 1'b0, 1'b0, 1'b0);
                3'd1:    ph = mk_phase(PK_RDWR,  1'b0, 1'b0, 1'b1, 1'b0);
                3'd2:    ph = mk_phase(PK_RDWR,  1'b1, 1'b1, 1'b0, 1'b0);
                3'd3:    ph = mk_phase(PK_RDWR,  1'b1, 1'b0, 1'b1, 1'b0);
                default: ph = mk_phase(PK_READ,  1'b0, 1'b1, 1'b0, 1'b1);
            endcase
            ALG_RMW: case (idx)
                3'd0:    ph = mk_phase(PK_WRITE, 1'b0, 1'b0, 1'b0, 1'b0);
                3'd1:    ph = mk_phase(PK_RMW,   1'b0, 1'b0, 1'b1, 1'b0);
                3'd2:    ph = mk_phase(PK_WRITE, 1'b0, 1'b0, 1'b1, 1'b0);
                3'd3:    ph = mk_phase(PK_RMW,   1'b0, 1'b1, 1'b0, 1'b0);
                default: ph = mk_phase(PK_READ,  1'b0, 1'b0, 1'b0, 1'b1);
            endcase
            ALG_PAGE: case (idx)
                3'd0:    ph = mk_phase(PK_WRITE, 1'b0, 1'b0, 1'b0, 1'b0);
                3'd1:    ph = mk_phase(PK_RDWR,  1'b0, 1'b0, 1'b1, 1'b0);
                default: ph = mk_phase(PK_RDWR,  1'b0, 1'b1, 1'b0, 1'b1);
            endcase
            default: case (idx)
                3'd0:    ph = mk_phase(PK_WRITE, 1'b0, 1'b0, 1'b0, 1'b0);
                3'd1:    ph = mk_phase(PK_PAUSE, 1'b0, 1'b0, 1'b0, 1'b0);
                3'd2:    ph = mk_phase(PK_READ,  1'b0, 1'b0, 1'b0, 1'b0);
                3'd3:    ph = mk_phase(PK_WRITE, 1'b0, 1'b0, 1'b1, 1'b0);
                3'd4:    ph = mk_phase(PK_PAUSE, 1'b0, 1'b0, 1'b0, 1'b0);
                default: ph = mk_phase(PK_READ,  1'b0, 1'b1, 1'b0, 1'b1);
            endcase
        endcase
    end
endmodule

// File: rtl/membist_addr_gen.sv
// Module: step counter and address former for one phase.
// Assumes: PAGE_AW < AW; the counter is cleared at each phase boundary.
//          It also times pauses, so it is CW bits wide.
module membist_addr_gen #(
    parameter int AW      = 6,
    parameter int PAGE_AW = 3,
    parameter int CW      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  step,
    input  logic                  paged,
    input  logic [AW-PAGE_AW-1:0] page,
    input  logic                  down,
    output logic [CW-1:0]         cnt,
    output logic                  at_end,
    output logic [AW-1:0]         addr
);
    localparam int DEPTH      = 1 << AW;
    localparam int PAGE_WORDS = 1 << PAGE_AW;

    logic [AW-1:0] span_last;
    logic [AW-1:0] base;
    logic [AW-1:0] off;

    // Purpose: count steps within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

    // Purpose: map the step count onto an address within the active span.
    always_comb begin
        span_last = paged ? AW'(PAGE_WORDS - 1) : AW'(DEPTH - 1);
        base      = paged ? {page, {PAGE_AW{1'b0}}} : '0;
        off       = cnt[AW-1:0];
        addr      = base + (down ? (span_last - off) : off);
        at_end    = (cnt == CW'(span_last));
    end
endmodule

// File: rtl/membist_compare.sv
// Module: read-data checker with a one-cycle pipeline, plus first-fail capture.
// Assumes: read data comes back exactly one cycle after the request.
module membist_compare #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          chk_v,
    input  logic [AW-1:0] chk_addr,
    input  logic [DW-1:0] chk_exp,
    input  logic [DW-1:0] rdata,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_act
);
    logic          pend_v;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_exp;
    logic          mismatch;

    // Purpose: hold the expectation of the read that is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_exp  <= '0;
        end else begin
            pend_v    <= chk_v;
            pend_addr <= chk_addr;
            pend_exp  <= chk_exp;
        end
    end

    assign mismatch = pend_v && (rdata != pend_exp);

    // Purpose: latch only the first mismatch; clear it on a new run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
            fail_exp  <= pend_exp;
            fail_act  <= rdata;
        end
    end
endmodule

// File: rtl/membist_seq.sv
// Module: top of the memory self-test sequencer.
// Steps through warm-up, the phase list of the chosen algorithm and a drain cycle.
// Assumes: a single-port RAM that takes one request per cycle and has one cycle
//          of read latency. PAUSE_CYC >= 1.
module membist_seq
    import membist_pkg::*;
#(
    parameter int          AW        = 6,
    parameter int          DW        = 16,
    parameter int          PAGE_AW   = 3,
    parameter int          PAUSE_CYC = 100,
    parameter logic [15:0] BG        = 16'h5A5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    alg_sel,
    output logic          mem_req,
    output logic [1:0]    mem_cmd,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_act
);
    localparam int PG_W  = AW - PAGE_AW;
    localparam int PW    = $clog2(PAUSE_CYC + 1);
    localparam int CW    = (PW > AW) ? PW : AW;
    localparam int WRM_W = $clog2(WARM_OPS);
    localparam logic [DW-1:0] BGW = DW'(BG);

    typedef enum logic [1:0] {S_IDLE, S_WARM, S_RUN, S_DRAIN} state_e;

    state_e           state;
    logic [2:0]       alg;
    logic [2:0]       pidx;
    logic [PG_W-1:0]  page;
    logic [WRM_W-1:0] warm;
    logic             sub;
    logic             done_q;

    phase_t           ph;
    logic [CW-1:0]    cnt;
    logic             at_end;
    logic             step;
    logic             ph_end;
    logic             accept;
    logic             chk_v;
    logic [DW-1:0]    wpat;
    logic [DW-1:0]    rpat;
    mem_cmd_e         cmd;

    membist_phase_rom u_rom (.alg(alg), .idx(pidx), .ph(ph));

    membist_addr_gen #(.AW(AW), .PAGE_AW(PAGE_AW), .CW(CW)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(accept || ph_end), .step(step),
        .paged(alg == ALG_PAGE), .page(page), .down(ph.down),
        .cnt(cnt), .at_end(at_end), .addr(mem_addr)
    );

    membist_compare #(.AW(AW), .DW(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clear(accept), .chk_v(chk_v),
        .chk_addr(mem_addr), .chk_exp(rpat), .rdata(mem_rdata),
        .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    assign accept  = (state == S_IDLE) && start && !alg_sel[2];
    assign busy    = (state != S_IDLE);
    assign done    = done_q;
    assign mem_cmd = cmd;

    // Purpose: decode the current phase and sub-step into this cycle's request.
    always_comb begin
        mem_req   = 1'b0;
        cmd       = CMD_DUMMY;
        mem_wdata = '0;
        chk_v     = 1'b0;
        step      = 1'b0;
        ph_end    = 1'b0;
        wpat      = BGW ^ {DW{ph.winv}};
        rpat      = BGW ^ {DW{ph.rinv}};
        if (state == S_WARM) begin
            mem_req = 1'b1;
        end else if (state == S_RUN) begin
            unique case (ph.kind)
                PK_WRITE: begin
                    mem_req = 1'b1; cmd = CMD_WRITE; mem_wdata = wpat;
                    step = 1'b1; ph_end = at_end;
                end
                PK_READ: begin
                    mem_req = 1'b1; cmd = CMD_READ; chk_v = 1'b1;
                    step = 1'b1; ph_end = at_end;
                end
                PK_RDWR: begin
                    mem_req = 1'b1;
                    if (sub) begin
                        cmd = CMD_WRITE; mem_wdata = wpat;
                        step = 1'b1; ph_end = at_end;
                    end else begin
                        cmd = CMD_READ; chk_v = 1'b1;
                    end
                end
                PK_RMW: begin
                    mem_req = 1'b1; cmd = CMD_RMW; mem_wdata = wpat; chk_v = 1'b1;
                    step = 1'b1; ph_end = at_end;
                end
                default: begin
                    step   = 1'b1;
                    ph_end = (cnt == CW'(PAUSE_CYC - 1));
                end
            endcase
        end
    end

    // Purpose: sequence the run state, the phase index, the page and the sub-step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            alg    <= '0;
            pidx   <= '0;
            page   <= '0;
            warm   <= '0;
            sub    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    state  <= S_WARM;
                    alg    <= alg_sel;
                    pidx   <= '0;
                    page   <= '0;
                    warm   <= '0;
                    sub    <= 1'b0;
                    done_q <= 1'b0;
                end
                S_WARM: begin
                    warm <= warm + 1'b1;
                    if (warm == WRM_W'(WARM_OPS - 1)) state <= S_RUN;
                end
                S_RUN: begin
                    if (ph.kind == PK_RDWR) sub <= ~sub;
                    if (ph_end) begin
                        if (!ph.last) begin
                            pidx <= pidx + 1'b1;
                        end else if (alg == ALG_PAGE && page != '1) begin
                            page <= page + 1'b1;
                            pidx <= '0;
                        end else begin
                            state <= S_DRAIN;
                        end
                    end
                end
                default: begin
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/membist_checker.sv
// Module: port-level protocol checks for membist_seq, attached by bind.
// Assumes: synchronous active-low reset; looks at the top-level ports only.
module membist_checker #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    alg_sel,
    input logic          mem_req,
    input logic [1:0]    mem_cmd,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [DW-1:0] fail_exp,
    input logic [DW-1:0] fail_act
);
    // R1: a valid start in idle begins a run with cleared results
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !alg_sel[2]) |=> (busy && !done && !fail));

    // R1: an out-of-range select leaves the block idle
    assert_ignore_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && alg_sel[2]) |=> !busy);

    // R2: the first request of a run is a dummy
    assert_warm_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && mem_cmd == 2'd0));

    // R7: fail is sticky for the rest of the run
    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fail) |=> fail);

    // R7: captured fields do not move once fail is set
    assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && $past(fail)) |-> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_act)));

    // R8: done and busy are never high together
    assert_done_busy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R8: done holds while no start arrives
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9: no request outside a run
    assert_req_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind membist_seq membist_checker #(.AW(AW), .DW(DW)) u_membist_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
    .mem_req(mem_req), .mem_cmd(mem_cmd), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
);

// File: tb/tb_membist_seq.sv
module tb_membist_seq;
    localparam int          AW      = 6;
    localparam int          DW      = 16;
    localparam int          PAGE_AW = 3;
    localparam int          PAUSE   = 100;
    localparam logic [15:0] BG      = 16'h5A5A;
    localparam int          DEPTH   = 1 << AW;
    localparam int          PWORDS  = 1 << PAGE_AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    alg_sel = '0;
    logic          mem_req;
    logic [1:0]    mem_cmd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_act;

    int checks = 0;
    int failures = 0;
    int run_cyc = 0;
    int t = 0;

    typedef struct { int cyc; int cmd; int addr; logic [15:0] wd; } item_t;
    item_t q[$];

    // RAM model with injectable faults
    logic [DW-1:0] mem [DEPTH];
    bit stuck_en = 0; int stuck_addr = 0;
    bit alias_en = 0; int alias_src = 0; int alias_dst = 0;

    membist_seq #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW), .PAUSE_CYC(PAUSE), .BG(BG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
        .mem_req(mem_req), .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] ram_rd(int a);
        logic [DW-1:0] r;
        r = mem[a];
        if (stuck_en && a == stuck_addr) r[0] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_cmd == 2'd1 || mem_cmd == 2'd3) mem_rdata <= ram_rd(int'(mem_addr));
            if (mem_cmd == 2'd2 || mem_cmd == 2'd3) begin
                mem[mem_addr] = mem_wdata;
                if (alias_en && int'(mem_addr) == alias_src) mem[alias_dst] = mem_wdata;
            end
        end
    end

    // run-relative cycle count: 0 in the first cycle after the accepting edge
    always @(posedge clk) begin
        if (start && !busy && !alg_sel[2]) run_cyc <= 0;
        else run_cyc <= run_cyc + 1;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(int cmd, int a, logic [15:0] wd);
        q.push_back('{t, cmd, a, wd});
        t++;
    endtask

    // kind: 0 write, 1 read, 2 read-then-write, 3 rmw
    task automatic elem(int kind, bit down, int base, int n, logic [15:0] w);
        for (int i = 0; i < n; i++) begin
            int a;
            a = base + (down ? n - 1 - i : i);
            case (kind)
                0: push(2, a, w);
                1: push(1, a, 16'h0);
                2: begin push(1, a, 16'h0); push(2, a, w); end
                default: push(3, a, w);
            endcase
        end
    endtask

    task automatic gen(int sel);
        q.delete();
        t = 0;
        repeat (8) push(0, 0, 16'h0);                       // R2 warm-up
        case (sel)
            0: begin                                         // R3 march
                elem(0, 0, 0, DEPTH, BG);
                elem(2, 0, 0, DEPTH, ~BG);
                elem(2, 1, 0, DEPTH, BG);
                elem(2, 1, 0, DEPTH, ~BG);
                elem(1, 0, 0, DEPTH, 16'h0);
            end
            1: begin                                         // R4 rmw
                elem(0, 0, 0, DEPTH, BG);
                elem(3, 0, 0, DEPTH, ~BG);
                elem(0, 0, 0, DEPTH, ~BG);
                elem(3, 0, 0, DEPTH, BG);
                elem(1, 0, 0, DEPTH, 16'h0);
            end
            2: begin                                         // R5 page
                for (int p = 0; p < DEPTH / PWORDS; p++) begin
                    elem(0, 0, p * PWORDS, PWORDS, BG);
                    elem(2, 0, p * PWORDS, PWORDS, ~BG);
                    elem(2, 0, p * PWORDS, PWORDS, BG);
                end
            end
            default: begin                                   // R6 retention
                elem(0, 0, 0, DEPTH, BG);
                t += PAUSE;
                elem(1, 0, 0, DEPTH, 16'h0);
                elem(0, 0, 0, DEPTH, ~BG);
                t += PAUSE;
                elem(1, 0, 0, DEPTH, 16'h0);
            end
        endcase
    endtask

    // scoreboard monitor: every request is popped and compared (R2..R6, R8, R9)
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (q.size() == 0) begin
                chk(0, "R9", "unexpected request cmd", mem_cmd, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(run_cyc == it.cyc, "R8", "request cycle", run_cyc, it.cyc);
                chk(int'(mem_cmd) == it.cmd, "R9", "request cmd", mem_cmd, it.cmd);
                if (it.cmd != 0)
                    chk(int'(mem_addr) == it.addr, "R3", "request addr", mem_addr, it.addr);
                if (it.cmd >= 2)
                    chk(mem_wdata == it.wd, "R4", "write data", mem_wdata, it.wd);
            end
        end
    end

    task automatic launch(int sel);
        @(negedge clk);
        start = 1'b1; alg_sel = 3'(sel);
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !fail, "R1", "busy/done/fail after start",
            {busy, done, fail}, 3'b100);
    endtask

    task automatic finish(string req);
        int n;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done, req, "run completed", done, 1);
        chk(run_cyc == t + 1, "R8", "done latency", run_cyc, t + 1);
        chk(!busy, "R8", "busy low at done", busy, 0);
        chk(q.size() == 0, req, "missing requests", q.size(), 0);
    endtask

    task automatic clear_ram();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_ram();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && !mem_req, "R1", "reset state",
            {busy, done, fail, mem_req}, 0);

        // R1: select 5 ignored
        start = 1'b1; alg_sel = 3'd5;
        @(negedge clk); start = 1'b0;
        chk(!busy && !mem_req, "R1", "select 5 ignored", busy, 0);

        // R3 march, with a start while busy that must be ignored (R1)
        gen(0); launch(0);
        repeat (40) @(negedge clk);
        start = 1'b1; alg_sel = 3'd1;
        @(negedge clk); start = 1'b0;
        finish("R3");
        chk(!fail, "R7", "march clean", fail, 0);

        // R1: ignored start keeps done
        start = 1'b1; alg_sel = 3'd6;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(done && !busy, "R1", "done kept after ignored start", done, 1);

        gen(1); launch(1); finish("R4");
        chk(!fail, "R7", "rmw clean", fail, 0);

        gen(2); launch(2); finish("R5");
        chk(!fail, "R7", "page clean", fail, 0);

        gen(3); launch(3); finish("R6");
        chk(!fail, "R6", "retention clean", fail, 0);

        // R7: stuck bit 0 at address 5
        stuck_en = 1; stuck_addr = 5;
        gen(0); launch(0); finish("R7");
        chk(fail, "R7", "stuck fail flag", fail, 1);
        chk(fail_addr == 6'd5, "R7", "stuck fail addr", fail_addr, 5);
        chk(fail_exp == 16'h5A5A, "R7", "stuck fail exp", fail_exp, 16'h5A5A);
        chk(fail_act == 16'h5A5B, "R7", "stuck fail act", fail_act, 16'h5A5B);
        stuck_en = 0;

        // R7: writes to 3 also land in 9
        alias_en = 1; alias_src = 3; alias_dst = 9;
        gen(0); launch(0); finish("R7");
        chk(fail, "R7", "alias fail flag", fail, 1);
        chk(fail_addr == 6'd9, "R7", "alias fail addr", fail_addr, 9);
        chk(fail_exp == 16'h5A5A, "R7", "alias fail exp", fail_exp, 16'h5A5A);
        chk(fail_act == 16'hA5A5, "R7", "alias fail act", fail_act, 16'hA5A5);
        alias_en = 0;

        // R1: fail cleared by the next accepted start, run clean
        gen(1); launch(1); finish("R1");
        chk(!fail, "R1", "fail cleared on new run", fail, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule